// File: doc/BRIEF.md
# Multicycle Path Capture Guard

This block sits on paths that need more than one clock to settle after their source registers load, for example a multiplier whose product is only valid two clocks after the operands change. Each guarded path has its own settle count. A false path is treated as a multicycle path with a very large count, such as 100. For each path the block counts the clock edges since the source group last loaded. It owns the destination register, so it sees every capture request.

A capture that arrives before the path's count has elapsed is premature. It produces a one-cycle violation pulse for that path. The block also reports a summary flag and the index of the lowest violating path, so the faulty path can be identified. Each path can be built in poison mode. In that mode a premature capture stores a fixed fill pattern instead of the data and raises a poison flag that travels with the stored value. That is the hardware counterpart of loading an unknown. A path without poison mode still stores the unsettled data, and only the violation pulse reports the early capture.

Top module: `mcg_guard_top`

## Requirements
- R1: After synchronous reset every stored data word, poison flag and violation output is zero. Each path starts as fully settled, so a capture issued before any source load is clean and stores the input data.
- R2: Let the loading edge be edge 0. A capture on rising edge k after it is premature when k is less than the path's cycle count N, and clean when k is N or more. For a premature capture, bit i of `viol_pulse` is 1 in the cycle that follows that edge. For a clean capture it is 0.
- R3: A source load and a capture of the same path on the same edge is always premature.
- R4: The elapsed count saturates and never wraps. A capture any number of idle cycles after a load, beyond N, is clean. A new load restarts the count from edge 0.
- R5: On a premature capture, a path in poison mode (bit i of `POISON_MASK` set; default paths 0 and 1) stores the all-ones fill value and sets `dst_poison[i]`. A path without poison mode (default path 2) stores the input data and leaves `dst_poison[i]` at 0.
- R6: A clean capture stores the input data and clears `dst_poison[i]`.
- R7: On an edge with no capture, the path's stored data and poison flag hold their values.
- R8: `viol_any` is 1 exactly when some bit of `viol_pulse` is 1. In that case `viol_id` gives the binary index of the lowest-numbered path whose bit is set.
- R9: Paths are independent. A load or capture on one path does not change the timing, data or flags of another path.
- R10: A violation pulse lasts one cycle. It falls again after an edge that carries no premature capture for that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_load | input | NUM_PATHS | Per path: source register group loads new operands this edge |
| dst_cap | input | NUM_PATHS | Per path: destination register captures this edge |
| src_data | input | NUM_PATHS*DATA_W | Per path data arriving through the slow path, path i at bits i*DATA_W upward |
| dst_data | output | NUM_PATHS*DATA_W | Per path captured value |
| dst_poison | output | NUM_PATHS | Per path flag: the stored value came from a premature capture |
| viol_pulse | output | NUM_PATHS | Per path premature-capture pulse |
| viol_any | output | 1 | Some path violated on the last edge |
| viol_id | output | ID_W | Lowest index among the violating paths |

## Verification
The assertions assume that reset is held for at least one edge before the inputs are used. They also assume that every cycle count is at least two, so that a load followed by a capture on the next edge is always premature. The stimulus only changes inputs on falling edges and starts with a held reset. It mixes directed sequences with random load and capture patterns. Those patterns often land captures exactly on the settle boundary, and in the same cycle as a load, on several paths at once.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_CLEAN = 2'd1,
        CAP_EARLY = 2'd2
    } cap_verdict_e;

    // Bits needed to hold the saturating limit n-1 (at least one bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mcg_settle_timer.sv
module mcg_settle_timer
    import mcg_pkg::*;
#(
    parameter int unsigned CYCLES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         cap,
    output cap_verdict_e verdict
);

    localparam int unsigned     CNT_W = cnt_width(CYCLES);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_s;

    timer_s st_d, st_q;
    logic   settled;

    always_comb begin
        st_d    = st_q;
        settled = (st_q.cnt == LIMIT) && !load;
        if (load) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (!cap) begin
            verdict = CAP_IDLE;
        end else if (settled) begin
            verdict = CAP_CLEAN;
        end else begin
            verdict = CAP_EARLY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= LIMIT;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LIMIT);                                            // R4
    AST_SAME_EDGE_EARLY: assert property (@(posedge clk) disable iff (rst)
        (load && cap) |-> verdict == CAP_EARLY);                       // R3
    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        load |=> !cap || verdict == CAP_EARLY || CYCLES < 2);         // R4

    generate
        if (CYCLES >= 2) begin : g_two_plus
            AST_EARLY_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
                ($past(load) && !$past(rst) && cap) |-> verdict == CAP_EARLY); // R2
        end
    endgenerate

endmodule

// File: rtl/mcg_capture_reg.sv
module mcg_capture_reg
    import mcg_pkg::*;
#(
    parameter int unsigned       DATA_W      = 16,
    parameter bit                POISON_EN   = 1'b1,
    parameter logic [DATA_W-1:0] POISON_FILL = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  cap_verdict_e      verdict,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              poison,
    output logic              viol
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              poison;
        logic              viol;
    } cap_s;

    cap_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.viol = 1'b0;
        case (verdict)
            CAP_CLEAN: begin
                st_d.data   = din;
                st_d.poison = 1'b0;
            end
            CAP_EARLY: begin
                st_d.viol   = 1'b1;
                st_d.data   = POISON_EN ? POISON_FILL : din;
                st_d.poison = POISON_EN;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout   = st_q.data;
    assign poison = st_q.poison;
    assign viol   = st_q.viol;

    AST_HOLD_NO_CAP: assert property (@(posedge clk) disable iff (rst)
        (verdict == CAP_IDLE) |=> $stable(dout) && $stable(poison));   // R7
    AST_VIOL_FROM_EARLY: assert property (@(posedge clk) disable iff (rst)
        viol |-> $past(verdict == CAP_EARLY));                         // R2
    AST_CLEAN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (verdict == CAP_CLEAN) |=> !poison && dout == $past(din));     // R6
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        (verdict != CAP_EARLY) |=> !viol);                             // R10

endmodule

// File: rtl/mcg_first_flag.sv
module mcg_first_flag #(
    parameter int unsigned N    = 3,
    parameter int unsigned ID_W = 2
) (
    input  logic [N-1:0]    vec,
    output logic            any,
    output logic [ID_W-1:0] id
);

    always_comb begin
        any = |vec;
        id  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) id = ID_W'(i);
        end
    end

endmodule

// File: rtl/mcg_guard_top.sv
module mcg_guard_top
    import mcg_pkg::*;
#(
    parameter int unsigned       NUM_PATHS               = 3,
    parameter int unsigned       DATA_W                  = 16,
    parameter int unsigned       PATH_CYCLES [NUM_PATHS] = '{2, 5, 100},
    parameter logic [NUM_PATHS-1:0] POISON_MASK          = 3'b011,
    parameter logic [DATA_W-1:0] POISON_FILL             = '1,
    localparam int unsigned      ID_W = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PATHS-1:0]          src_load,
    input  logic [NUM_PATHS-1:0]          dst_cap,
    input  logic [NUM_PATHS*DATA_W-1:0]   src_data,
    output logic [NUM_PATHS*DATA_W-1:0]   dst_data,
    output logic [NUM_PATHS-1:0]          dst_poison,
    output logic [NUM_PATHS-1:0]          viol_pulse,
    output logic                          viol_any,
    output logic [ID_W-1:0]               viol_id
);

    cap_verdict_e verdict [NUM_PATHS];

    generate
        for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
            mcg_settle_timer #(
                .CYCLES (PATH_CYCLES[g])
            ) u_timer (
                .clk     (clk),
                .rst     (rst),
                .load    (src_load[g]),
                .cap     (dst_cap[g]),
                .verdict (verdict[g])
            );

            mcg_capture_reg #(
                .DATA_W      (DATA_W),
                .POISON_EN   (POISON_MASK[g]),
                .POISON_FILL (POISON_FILL)
            ) u_cap (
                .clk     (clk),
                .rst     (rst),
                .verdict (verdict[g]),
                .din     (src_data[g*DATA_W +: DATA_W]),
                .dout    (dst_data[g*DATA_W +: DATA_W]),
                .poison  (dst_poison[g]),
                .viol    (viol_pulse[g])
            );
        end
    endgenerate

    mcg_first_flag #(
        .N    (NUM_PATHS),
        .ID_W (ID_W)
    ) u_first (
        .vec (viol_pulse),
        .any (viol_any),
        .id  (viol_id)
    );

    AST_ID_POINTS_AT_VIOL: assert property (@(posedge clk) disable iff (rst)
        viol_any |-> viol_pulse[viol_id]);                             // R8
    AST_ID_LOWEST: assert property (@(posedge clk) disable iff (rst)
        viol_any |-> (viol_pulse & ((NUM_PATHS'(1) << viol_id) - 1'b1)) == '0); // R8
    AST_VIOL_NEEDS_CAP: assert property (@(posedge clk) disable iff (rst)
        (dst_cap == '0) |=> viol_pulse == '0);                         // R9
    AST_POISON_ONLY_MASK: assert property (@(posedge clk) disable iff (rst)
        (dst_poison & ~POISON_MASK) == '0);                            // R5

endmodule

// File: tb/tb_mcg_guard_top.sv
module tb_mcg_guard_top;

    localparam int NP = 3;
    localparam int DW = 16;
    localparam int CYC [NP] = '{2, 5, 100};
    localparam logic [NP-1:0] PMASK = 3'b011;
    localparam logic [DW-1:0] FILL = '1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP-1:0]     src_load = '0;
    logic [NP-1:0]     dst_cap = '0;
    logic [NP*DW-1:0]  src_data = '0;
    logic [NP*DW-1:0]  dst_data;
    logic [NP-1:0]     dst_poison;
    logic [NP-1:0]     viol_pulse;
    logic              viol_any;
    logic [1:0]        viol_id;

    int n_tests = 0;
    int n_fail  = 0;

    int              age   [NP];
    logic [DW-1:0]   e_data[NP];
    logic [NP-1:0]   e_pois, e_viol;

    always #10 clk = ~clk;   // 50 MHz

    mcg_guard_top dut (
        .clk        (clk),
        .rst        (rst),
        .src_load   (src_load),
        .dst_cap    (dst_cap),
        .src_data   (src_data),
        .dst_data   (dst_data),
        .dst_poison (dst_poison),
        .viol_pulse (viol_pulse),
        .viol_any   (viol_any),
        .viol_id    (viol_id)
    );

    function automatic logic [1:0] lowest(input logic [NP-1:0] v);
        for (int i = NP - 1; i >= 0; i--) if (v[i]) lowest = 2'(i);
        if (v == '0) lowest = 2'd0;
    endfunction

    function automatic logic is_early(input int a, input logic ld, input int n);
        return ld || (a + 1 < n);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        for (int i = 0; i < NP; i++) begin
            chk(tag, $sformatf("data[%0d]", i), 32'(dst_data[i*DW +: DW]), 32'(e_data[i]));
        end
        chk(tag, "poison", 32'(dst_poison), 32'(e_pois));
        chk(tag, "viol_pulse", 32'(viol_pulse), 32'(e_viol));
        chk(tag, "viol_any", 32'(viol_any), 32'(|e_viol));
        if (|e_viol) chk(tag, "viol_id", 32'(viol_id), 32'(lowest(e_viol)));
    endtask

    task automatic step(input logic [NP-1:0] ld, input logic [NP-1:0] cp, input string tag);
        logic [NP*DW-1:0] d;
        logic             early;
        for (int i = 0; i < NP; i++) d[i*DW +: DW] = DW'($urandom);
        src_load = ld;
        dst_cap  = cp;
        src_data = d;
        e_viol   = '0;
        for (int i = 0; i < NP; i++) begin
            early = is_early(age[i], ld[i], CYC[i]);
            if (cp[i]) begin
                e_viol[i] = early;
                e_pois[i] = early && PMASK[i];
                e_data[i] = (early && PMASK[i]) ? FILL : d[i*DW +: DW];
            end
            if (ld[i]) age[i] = 0;
            else if (age[i] < 1000) age[i] = age[i] + 1;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step('0, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NP; i++) begin
            age[i]    = 1000;
            e_data[i] = '0;
        end
        e_pois = '0;
        e_viol = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R1 reset");

        step('0, 3'b111, "R1 capture before load");
        idle(1, "R7 hold");
        // two-cycle path: early then clean capture
        step(3'b001, '0, "R2 load p0");
        step('0, 3'b001, "R2 R5 early p0");
        step('0, 3'b001, "R6 clean p0");
        idle(1, "R10 pulse falls");
        step(3'b001, 3'b001, "R3 same edge p0");
        step('0, '0, "R7 hold");
        step('0, 3'b001, "R2 boundary p0");
        // five-cycle path: edge 4 early, edge 5 clean
        step(3'b010, '0, "R2 load p1");
        idle(3, "R9 idle");
        step('0, 3'b010, "R2 edge4 p1");
        step('0, 3'b010, "R6 edge5 p1");
        // restart by reload
        step(3'b010, '0, "R4 load p1");
        idle(3, "R4 idle");
        step(3'b010, '0, "R4 reload p1");
        idle(3, "R4 idle");
        step('0, 3'b010, "R4 early after reload");
        // false path without poison
        step(3'b100, '0, "R5 load p2");
        idle(98, "R9 idle");
        step('0, 3'b100, "R5 early p2 no poison");
        idle(200, "R4 saturate");
        step('0, 3'b100, "R4 clean after long idle");
        // several violations at once, lowest index reported
        step(3'b110, '0, "R8 load p1 p2");
        step('0, 3'b111, "R8 multi viol");
        step(3'b001, 3'b010, "R9 independence");
        step('0, 3'b100, "R8 only p2");

        for (int k = 0; k < 3000; k++) begin
            logic [NP-1:0] ld, cp;
            for (int i = 0; i < NP; i++) begin
                ld[i] = ($urandom % 8) == 0;
                cp[i] = ($urandom % 3) == 0;
            end
            step(ld, cp, "R2 R9 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule